// File: doc/BRIEF.md
# Programmable Local Countdown Timer

This block is a countdown timer that sits beside one processor. A base clock feeds a power-of-two prescaler. Each prescaler tick moves a counter one step toward zero. The counter is loaded through a 32-bit register port. When it reaches zero, the timer issues a one-cycle request that carries an 8-bit vector and an edge/level flag. The flag is always edge. That request goes to the interrupt priority logic, which is not part of this block.

Two modes are selectable in the timer's vector entry register:

- **One-shot:** the count stops at zero.
- **Periodic:** the count reloads the stored initial value on the step after zero, so requests repeat every (initial + 1) steps.

A mask bit in the same register suppresses requests while the count keeps running. Software can read the live count at any time.

Register indices on `reg_addr`: 0x32 vector entry, 0x38 initial count, 0x39 current count, 0x3E divide setting.

Top module: `local_tick_timer`

## Requirements
- R1: A write to the divide register (0x3E) keeps only bits 3, 1 and 0 of the data (value & 0xB). A read returns the stored value in those same positions, so writing 0xF reads back 0xB.
- R2: The divide code is {bit3, bit1, bit0}. The step shift is (code + 1) mod 8, and the count moves once every 2^shift clocks. Examples: 0x0 divides by 2, 0x3 by 16, 0x8 by 32, 0xA by 128, and 0xB by 1.
- R3: A write to the initial count (0x38) stores the value, loads it as the current count and restarts the prescaler. The first step comes 2^shift clocks after the write edge, including when the write lands in the middle of a count.
- R4: In one-shot mode (entry bit 17 = 0), the count falls to 0 and then stays at 0 without further requests. The current count never exceeds the initial count.
- R5: In periodic mode (entry bit 17 = 1), the step after the count reads 0 reloads the initial count. Requests therefore repeat every (initial + 1) × 2^shift clocks.
- R6: When a step brings the count to 0, `irq_req` is high for exactly one clock. That clock is the first one in which the count reads 0. During it, `irq_vector` equals entry bits 7:0 and `irq_level` is 0 (edge).
- R7: When entry bit 16 (mask) is set, no request is issued at expiry, but the count still reaches 0.
- R8: An initial count of 0 stops the timer: the count stays at 0 and no request is issued in either mode.
- R9: Reading index 0x39 returns the live current count. Writes to 0x39 have no effect.
- R10: The entry (0x32) reads back bits 17, 16 and 7:0, with all other bits 0. A mode change takes effect at the next step: an expired one-shot count switched to periodic reloads on the next step.
- R11: After reset, the entry reads 0x00010000 (masked), and the initial count, current count and divide register all read 0. Unmapped indices read 0, and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register index for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_req | output | 1 | One-clock expiry request |
| irq_vector | output | 8 | Vector carried with the request |
| irq_level | output | 1 | Trigger flag, 0 = edge |

## Verification
The bench measures the clocks from the initial-count write to the request for every divide code, including the all-ones code. A wrong divide decode would show up as a distance of the wrong power of two, and a missing prescaler restart as a first step that arrives early.

Several further cases are targeted:

- **Periodic spacing:** the bench checks that requests come init + 1 steps apart. A reload placed on the zero step itself would give a spacing of init.
- **Expired one-shot:** the bench checks that the count holds at 0 and stays silent. It then checks that switching the mode to periodic revives the count.
- **Silent cases:** a masked entry, an initial count of 0 and a write to the read-only count must all leave the timer silent or unchanged. A design that fires anyway, or that lets the read-only index load the counter, is caught.

// File: rtl/ltt_pkg.sv
package ltt_pkg;

    // register indices; fixed because software addresses them
    localparam logic [7:0] IDX_ENTRY = 8'h32;
    localparam logic [7:0] IDX_INIT  = 8'h38;
    localparam logic [7:0] IDX_CUR   = 8'h39;
    localparam logic [7:0] IDX_DIV   = 8'h3E;

    localparam int SHIFT_W = 3;
    localparam int VEC_W   = 8;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vec;
    } ltt_entry_t;

    localparam ltt_entry_t ENTRY_RST = '{periodic: 1'b0, masked: 1'b1, vec: '0};
    localparam logic TRIG_EDGE = 1'b0;

endpackage

// File: rtl/ltt_prescale.sv
module ltt_prescale #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PRE_W = (1 << SHIFT_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_t;

    pre_t             s_d, s_q;
    logic [PRE_W-1:0] low_mask;

    always_comb begin
        s_d      = s_q;
        low_mask = (PRE_W'(1) << shift) - PRE_W'(1);
        tick     = (s_q.pre & low_mask) == low_mask;
        if (restart) begin
            s_d.pre = '0;
        end else begin
            s_d.pre = s_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ltt_count.sv
module ltt_count #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic             masked,
    input  logic [VEC_W-1:0] vec,
    output logic [CNT_W-1:0] cur,
    output logic [CNT_W-1:0] init,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec
);
    typedef struct packed {
        logic [CNT_W-1:0] init;
        logic [CNT_W-1:0] cur;
        logic             irq;
        logic [VEC_W-1:0] vec;
    } cnt_t;

    cnt_t s_d, s_q;
    logic running;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        running = s_q.init != '0;
        if (load) begin
            s_d.init = load_val;
            s_d.cur  = load_val;
        end else if (tick && running) begin
            if (s_q.cur == '0) begin
                // zero reached earlier: periodic reloads, one-shot holds
                if (periodic) begin
                    s_d.cur = s_q.init;
                end
            end else begin
                s_d.cur = s_q.cur - CNT_W'(1);
                if (s_q.cur == CNT_W'(1) && !masked) begin
                    s_d.irq = 1'b1;
                    s_d.vec = vec;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur     = s_q.cur;
    assign init    = s_q.init;
    assign irq_req = s_q.irq;
    assign irq_vec = s_q.vec;

endmodule

// File: rtl/local_tick_timer.sv
module local_tick_timer
    import ltt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector,
    output logic              irq_level
);
    typedef struct packed {
        logic [SHIFT_W-1:0] code;
        ltt_entry_t         ent;
    } cfg_t;

    cfg_t               c_d, c_q;
    logic               load_init;
    logic               tick;
    logic [SHIFT_W-1:0] shift;
    logic [CNT_W-1:0]   cnt_cur;
    logic [CNT_W-1:0]   cnt_init;

    always_comb begin
        c_d       = c_q;
        load_init = reg_wr && (reg_addr == IDX_INIT);
        if (reg_wr && reg_addr == IDX_DIV) begin
            c_d.code = {reg_wdata[3], reg_wdata[1:0]};
        end
        if (reg_wr && reg_addr == IDX_ENTRY) begin
            c_d.ent = '{periodic: reg_wdata[17], masked: reg_wdata[16],
                        vec: reg_wdata[VEC_W-1:0]};
        end
        shift = c_q.code + SHIFT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{code: '0, ent: ENTRY_RST};
        end else begin
            c_q <= c_d;
        end
    end

    ltt_prescale #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_init),
        .shift   (shift),
        .tick    (tick)
    );

    ltt_count #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_init),
        .load_val (reg_wdata[CNT_W-1:0]),
        .tick     (tick),
        .periodic (c_q.ent.periodic),
        .masked   (c_q.ent.masked),
        .vec      (c_q.ent.vec),
        .cur      (cnt_cur),
        .init     (cnt_init),
        .irq_req  (irq_req),
        .irq_vec  (irq_vector)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_ENTRY: reg_rdata = {14'd0, c_q.ent.periodic, c_q.ent.masked,
                                    8'd0, c_q.ent.vec};
            IDX_INIT:  reg_rdata = 32'(cnt_init);
            IDX_CUR:   reg_rdata = 32'(cnt_cur);
            IDX_DIV:   reg_rdata = {28'd0, c_q.code[2], 1'b0, c_q.code[1:0]};
            default:   reg_rdata = '0;
        endcase
    end

    assign irq_level = TRIG_EDGE;

endmodule

// File: rtl/ltt_checker.sv
module ltt_checker #(
    parameter int CNT_W   = 32,
    parameter int SHIFT_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load,
    input logic               tick,
    input logic [SHIFT_W-1:0] shift,
    input logic               periodic,
    input logic               masked,
    input logic [CNT_W-1:0]   cur,
    input logic [CNT_W-1:0]   init,
    input logic               irq_req
);
    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift == '0) |-> tick); // R2

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (cur == '0)); // R6

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req); // R6

    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !$past(masked)); // R7

    AST_CUR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cur <= init); // R4

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && cur == '0 && !load) |=> (cur == '0)); // R4

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (init == '0) |-> !irq_req); // R8

endmodule

bind local_tick_timer ltt_checker #(.CNT_W(CNT_W), .SHIFT_W(ltt_pkg::SHIFT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_init),
    .tick     (tick),
    .shift    (shift),
    .periodic (c_q.ent.periodic),
    .masked   (c_q.ent.masked),
    .cur      (cnt_cur),
    .init     (cnt_init),
    .irq_req  (irq_req)
);

// File: tb/tb_local_tick_timer.sv
`timescale 1ns/1ps
module tb_local_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [7:0]  irq_vector;
    logic        irq_level;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    local_tick_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .irq_vector(irq_vector), .irq_level(irq_level)
    );

    localparam int NV = 9;
    localparam logic [3:0]  DIVS  [NV] = '{4'hB, 4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'hF};
    localparam logic [31:0] INITS [NV] = '{32'd5, 32'd3, 32'd3, 32'd2, 32'd2, 32'd1, 32'd1, 32'd1, 32'd4};

    function automatic int clocks_per_step(logic [3:0] d);
        logic [2:0] code;
        code = {d[3], d[1], d[0]};
        return 1 << ((int'(code) + 1) % 8);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_irq(int max, output int n);
        n = -1;
        for (int k = 1; k <= max; k++) begin
            @(negedge clk);
            if (irq_req) begin
                n = k;
                break;
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 irq low", {31'd0, irq_req}, 32'd0);
        rd(8'h32, v); check("R11 entry", v, 32'h0001_0000);
        rd(8'h38, v); check("R11 init", v, 32'd0);
        rd(8'h39, v); check("R11 cur", v, 32'd0);
        rd(8'h3E, v); check("R11 div", v, 32'd0);
        rd(8'h20, v); check("R11 unmapped", v, 32'd0);

        // vector table: R1 R2 R3 R6 distance from load to expiry
        for (int i = 0; i < NV; i++) begin
            wr(8'h3E, {28'd0, DIVS[i]});
            rd(8'h3E, v); check("R1 div readback", v, {28'd0, DIVS[i] & 4'hB});
            wr(8'h32, 32'h0000_0030 + 32'(i));
            wr(8'h38, INITS[i]);
            wait_irq(300, n);
            check("R2 R3 expiry distance", 32'(n), INITS[i] * 32'(clocks_per_step(DIVS[i])));
            check("R6 vector", {24'd0, irq_vector}, 32'h30 + 32'(i));
            check("R6 edge flag", {31'd0, irq_level}, 32'd0);
            @(negedge clk);
            check("R6 one-cycle pulse", {31'd0, irq_req}, 32'd0);
        end

        // R10 entry readback of the three fields
        wr(8'h32, 32'hFFFF_FFFF);
        rd(8'h32, v); check("R10 entry fields", v, 32'h0003_00FF);

        // R4 one-shot holds at 0 and stays silent
        wr(8'h3E, 32'hB);
        wr(8'h32, 32'h0000_0022);
        wr(8'h38, 32'd3);
        wait_irq(20, n); check("R4 oneshot fires", 32'(n), 32'd3);
        wait_irq(10, n); check("R4 no refire", 32'(n), 32'hFFFF_FFFF);
        rd(8'h39, v); check("R4 held at zero", v, 32'd0);
        // R10 switching to periodic revives the count on the next step
        wr(8'h32, 32'h0002_0022);
        wait_irq(20, n); check("R10 revive after mode change", 32'(n), 32'd4);

        // R5 periodic spacing init+1
        wr(8'h32, 32'h0002_0041);
        wr(8'h38, 32'd3);
        wait_irq(20, n); check("R5 first expiry", 32'(n), 32'd3);
        wait_irq(20, n); check("R5 period", 32'(n), 32'd4);
        wait_irq(20, n); check("R5 period again", 32'(n), 32'd4);
        check("R5 vector", {24'd0, irq_vector}, 32'h41);

        // R9 live count with divide by 2
        wr(8'h32, 32'h0000_0011);
        wr(8'h3E, 32'h0);
        wr(8'h38, 32'd10);
        repeat (7) @(negedge clk);
        rd(8'h39, v); check("R9 live count", v, 32'd7);

        // R9 write to current-count index is ignored
        wr(8'h3E, 32'hA);
        wr(8'h38, 32'd100);
        wr(8'h39, 32'h55);
        rd(8'h39, v); check("R9 write ignored", v, 32'd100);
        rd(8'h38, v); check("R9 init unchanged", v, 32'd100);

        // R3 restart mid-count
        wr(8'h3E, 32'hB);
        wr(8'h38, 32'd10);
        repeat (3) @(negedge clk);
        wr(8'h38, 32'd3);
        wait_irq(20, n); check("R3 restart mid-count", 32'(n), 32'd3);

        // R7 masked: no request, count still reaches zero
        wr(8'h32, 32'h0001_0011);
        wr(8'h38, 32'd2);
        wait_irq(20, n); check("R7 masked silent", 32'(n), 32'hFFFF_FFFF);
        rd(8'h39, v); check("R7 count expired", v, 32'd0);

        // R8 initial 0 stops the timer, even in periodic mode
        wr(8'h32, 32'h0002_0011);
        wr(8'h38, 32'd0);
        wait_irq(30, n); check("R8 stopped silent", 32'(n), 32'hFFFF_FFFF);
        rd(8'h39, v); check("R8 count zero", v, 32'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule